// File: doc/BRIEF.md
# Indexed Block Register Slave on a Two-Wire Serial Bus

This block is a slave on an I2C bus that holds a small file of control registers for a clock distribution circuit. It has enable bits for two output drivers and two 8-bit divider selects for programmable divided outputs. It also returns a fixed identification byte. The block runs on a fast system clock. It oversamples SCL and SDA, passes each through a two-flop synchronizer, then filters out pulses shorter than three samples before it looks for edges. SDA is driven open-drain: `sda_oe` high pulls the line low.

Every transaction uses a block protocol. A write carries the starting register index, then a byte count, then the data. A read first sets the index with a write-mode address, then issues a repeated start with the read address. The slave then answers with a byte count followed by the register contents. The register pointer advances after each byte. A STOP seen in the middle of a byte abandons that byte, and bytes committed earlier stay written.

Top module: `i2c_idxblk_regs`

## Requirements
- R1: The slave responds only to the 7-bit address 1101010, so address bytes D4h (write) and D5h (read) are ACKed. Any other address byte gets no ACK, and the bus is then ignored until the next START or STOP.
- R2: A write transaction carries the index byte N, then the count byte X, then data bytes. Every one of these bytes is ACKed. Data byte k goes to register N+k, for k below X.
- R3: After a write-mode address and an index byte, a repeated START with D5h starts a read. The slave sends a count byte and then register bytes, MSB first, for as long as the master ACKs. A NACK from the master ends the sending.
- R4: The count byte sent in a read equals 7−N when the index N is 6 or less, and equals 0 otherwise.
- R5: Register 0 bit 5 drives `out3_en` and bit 4 drives `out4_en`; both reset to 1. Register 1 drives `div_a` and resets to 0Fh. Register 2 drives `div_b` and resets to 2Eh. A committed write appears on these ports.
- R6: Register 6 reads 01h (revision 0 in bits 7:4, vendor 1 in bits 3:0). Registers 3 to 5 and the unused bits of register 0 read as 0.
- R7: A write to register 6 or to a reserved location is ACKed and changes nothing.
- R8: Data bytes sent after the count X is used up are ACKed and discarded.
- R9: The pointer increments after each byte that is transferred. Any index above 6 reads 00h.
- R10: A STOP in the middle of a byte aborts the transfer and releases SDA. The partial byte is not committed, and bytes committed earlier are kept.
- R11: A low pulse on SCL that lasts two system clocks or less is not seen as a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used for oversampling |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line, as sensed |
| sda_i | input | 1 | Bus data line, as sensed |
| sda_oe | output | 1 | Pull SDA low when 1 |
| out3_en | output | 1 | Enable for output 3 (register 0 bit 5) |
| out4_en | output | 1 | Enable for output 4 (register 0 bit 4) |
| div_a | output | 8 | Divider select from register 1 |
| div_b | output | 8 | Divider select from register 2 |

## Verification
The bench goes after several boundary cases. A read is started at index 5 and runs past the last register; a design with an off-by-one in the pointer or in the count would return 01h one byte early or a nonzero trailing byte. Writes send one byte more than the count. They also target the identification register and set the reserved bits of register 0, which would reveal a slave that commits everything it ACKs. One write is cut off by a STOP after four bits, and another is run with short SCL glitches inside every high phase. A design without the filter would shift in extra bits, and a design without abort handling would commit a half byte or keep pulling SDA low. A wrong address byte that still got an ACK, or that changed a register afterwards, is also reported.

// File: rtl/i2c_idxblk_regs.sv
module i2c_idxblk_regs #(
  parameter logic [6:0] DEV_ADDR  = 7'b1101010,
  parameter int         SYNC_LEN  = 2,
  parameter int         FILT_LEN  = 3,
  parameter int         LAST_IDX  = 6,
  parameter logic [3:0] REV_ID    = 4'h0,
  parameter logic [3:0] VEND_ID   = 4'h1,
  parameter logic [7:0] DIV_A_RST = 8'h0F,
  parameter logic [7:0] DIV_B_RST = 8'h2E
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  output logic       out3_en,
  output logic       out4_en,
  output logic [7:0] div_a,
  output logic [7:0] div_b
);

  localparam logic [7:0] LAST   = 8'(LAST_IDX);
  localparam logic [7:0] ID_IDX = LAST;

  typedef enum logic [2:0] {S_IDLE, S_RX, S_ACKW, S_ACKH, S_TX, S_TACK, S_TNXT, S_WAIT} st_t;
  typedef enum logic [1:0] {P_ADDR, P_IDX, P_CNT, P_DATA} ph_t;

  logic [SYNC_LEN-1:0] scl_sy, sda_sy;
  logic [FILT_LEN-1:0] scl_h, sda_h;
  logic scl_f, sda_f, scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= '1; sda_sy <= '1;
      scl_h  <= '1; sda_h  <= '1;
      scl_f  <= 1'b1; sda_f <= 1'b1;
      scl_p  <= 1'b1; sda_p <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[SYNC_LEN-2:0], scl_i};
      sda_sy <= {sda_sy[SYNC_LEN-2:0], sda_i};
      scl_h  <= {scl_h[FILT_LEN-2:0], scl_sy[SYNC_LEN-1]};
      sda_h  <= {sda_h[FILT_LEN-2:0], sda_sy[SYNC_LEN-1]};
      if (&scl_h) scl_f <= 1'b1; else if (~|scl_h) scl_f <= 1'b0;
      if (&sda_h) sda_f <= 1'b1; else if (~|sda_h) sda_f <= 1'b0;
      scl_p  <= scl_f;
      sda_p  <= sda_f;
    end
  end

  wire scl_rise  = ~scl_p &  scl_f;
  wire scl_fall  =  scl_p & ~scl_f;
  wire start_det =  scl_p & scl_f &  sda_p & ~sda_f;
  wire stop_det  =  scl_p & scl_f & ~sda_p &  sda_f;

  st_t        st;
  ph_t        ph;
  logic       rd_mode;
  logic [3:0] bitcnt;
  logic [6:0] shr;
  logic [7:0] tx_sh, ptr, remain, rd_cur;

  wire [7:0] rx_byte = {shr, sda_f};
  wire [7:0] cnt_out = (ptr <= LAST) ? (LAST + 8'd1 - ptr) : 8'd0;

  always_comb begin
    rd_cur = 8'h00;
    if (ptr == 8'd0)        rd_cur = {2'b00, out3_en, out4_en, 4'b0000};
    else if (ptr == 8'd1)   rd_cur = div_a;
    else if (ptr == 8'd2)   rd_cur = div_b;
    else if (ptr == ID_IDX) rd_cur = {REV_ID, VEND_ID};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; ph <= P_ADDR; rd_mode <= 1'b0;
      bitcnt <= '0; shr <= '0; tx_sh <= '0; ptr <= '0; remain <= '0;
      sda_oe <= 1'b0;
      out3_en <= 1'b1; out4_en <= 1'b1;
      div_a <= DIV_A_RST; div_b <= DIV_B_RST;
    end else if (stop_det) begin
      st <= S_IDLE; sda_oe <= 1'b0;
    end else if (start_det) begin
      st <= S_RX; ph <= P_ADDR; bitcnt <= '0; sda_oe <= 1'b0;
    end else if (scl_rise) begin
      case (st)
        S_RX: begin
          shr <= rx_byte[6:0];
          if (bitcnt != 4'd7) bitcnt <= bitcnt + 4'd1;
          else begin
            st <= S_ACKW;
            case (ph)
              P_ADDR: begin
                rd_mode <= rx_byte[0];
                ph      <= P_IDX;
                if (rx_byte[7:1] != DEV_ADDR) st <= S_WAIT;
              end
              P_IDX: begin ptr <= rx_byte; ph <= P_CNT; end
              P_CNT: begin remain <= rx_byte; ph <= P_DATA; end
              default: if (remain != 8'd0) begin
                remain <= remain - 8'd1;
                ptr    <= ptr + 8'd1;
                if (ptr == 8'd0) begin out3_en <= rx_byte[5]; out4_en <= rx_byte[4]; end
                else if (ptr == 8'd1) div_a <= rx_byte;
                else if (ptr == 8'd2) div_b <= rx_byte;
              end
            endcase
          end
        end
        S_TACK: st <= sda_f ? S_WAIT : S_TNXT;
        default: ;
      endcase
    end else if (scl_fall) begin
      case (st)
        S_ACKW: begin sda_oe <= 1'b1; st <= S_ACKH; end
        S_ACKH: begin
          if (rd_mode && ph == P_IDX) begin
            rd_mode <= 1'b0;
            tx_sh   <= cnt_out;
            sda_oe  <= ~cnt_out[7];
            bitcnt  <= 4'd1;
            st      <= S_TX;
          end else begin
            sda_oe <= 1'b0;
            bitcnt <= '0;
            st     <= S_RX;
          end
        end
        S_TX: begin
          if (bitcnt == 4'd8) begin sda_oe <= 1'b0; st <= S_TACK; end
          else begin
            sda_oe <= ~tx_sh[6];
            tx_sh  <= {tx_sh[6:0], 1'b0};
            bitcnt <= bitcnt + 4'd1;
          end
        end
        S_TNXT: begin
          tx_sh  <= rd_cur;
          sda_oe <= ~rd_cur[7];
          ptr    <= ptr + 8'd1;
          bitcnt <= 4'd1;
          st     <= S_TX;
        end
        default: ;
      endcase
    end
  end

endmodule

module i2c_idxblk_regs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_f,
  input logic       start_det,
  input logic       stop_det,
  input logic       sda_oe,
  input logic       out3_en,
  input logic       out4_en,
  input logic [7:0] div_a,
  input logic [7:0] div_b
);
  a_r5_reset_vals: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (div_a == 8'h0F && div_b == 8'h2E && out3_en && out4_en));

  a_r2_write_on_scl_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (div_a != $past(div_a) || div_b != $past(div_b)) |-> $past(scl_f));

  a_r10_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);

  a_r3_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> (!$past(scl_f) || $past(stop_det) || $past(start_det)));
endmodule

bind i2c_idxblk_regs i2c_idxblk_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .start_det(start_det), .stop_det(stop_det),
  .sda_oe(sda_oe), .out3_en(out3_en), .out4_en(out4_en), .div_a(div_a), .div_b(div_b)
);

// File: tb/tb_i2c_idxblk_regs.sv
module tb_i2c_idxblk_regs;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic glitch = 1'b0;
  logic sda_oe, out3_en, out4_en;
  logic [7:0] div_a, div_b;
  wire sda_line = sda_m & ~sda_oe;

  localparam int Q = 16;

  always #2 clk = ~clk;

  i2c_idxblk_regs dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .out3_en(out3_en), .out4_en(out4_en), .div_a(div_a), .div_b(div_b)
  );

  int checks = 0;
  int errors = 0;
  int exp_q[$];
  int act_q[$];
  string tag_q[$];
  event got;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always begin
    @(got);
    if (act_q.size() > 0 && exp_q.size() > 0)
      chk(tag_q.pop_front(), act_q.pop_front(), exp_q.pop_front());
  end

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2c_start;
    sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q); sda_m = 1'b0; wq(Q); scl_m = 1'b0; wq(Q);
  endtask

  task automatic i2c_stop;
    sda_m = 1'b0; wq(Q); scl_m = 1'b1; wq(Q); sda_m = 1'b1; wq(2 * Q);
  endtask

  task automatic bit_io(input logic b, output logic r);
    sda_m = b; wq(Q);
    scl_m = 1'b1;
    if (glitch) begin
      wq(6); scl_m = 1'b0; wq(2); scl_m = 1'b1; wq(Q - 8);
    end else wq(Q);
    r = sda_line;
    wq(Q); scl_m = 1'b0; wq(Q);
  endtask

  task automatic wr_byte(input logic [7:0] b, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) bit_io(b[i], r);
    bit_io(1'b1, r);
    ack = ~r;
  endtask

  task automatic rd_byte(input logic mack, output logic [7:0] b);
    logic r;
    for (int i = 7; i >= 0; i--) begin bit_io(1'b1, r); b[i] = r; end
    bit_io(~mack, r);
  endtask

  task automatic write_txn(input string req, input logic [7:0] idx, input logic [7:0] cnt,
                           input logic [7:0] d0, input logic [7:0] d1, input int n);
    logic a0, a1, a2, a3, a4;
    i2c_start;
    wr_byte(8'hD4, a0); wr_byte(idx, a1); wr_byte(cnt, a2);
    a3 = 1'b1; a4 = 1'b1;
    if (n > 0) wr_byte(d0, a3);
    if (n > 1) wr_byte(d1, a4);
    i2c_stop;
    chk({req, " acks"}, int'({a0, a1, a2, a3, a4}), 5'b11111);
  endtask

  task automatic read_txn(input string req, input logic [7:0] idx, input int n, input int ecnt,
                          input logic [7:0] e0, input logic [7:0] e1, input logic [7:0] e2,
                          input logic [7:0] e3, input logic [7:0] e4, input logic [7:0] e5,
                          input logic [7:0] e6);
    logic a0, a1, a2;
    logic [7:0] b;
    logic [7:0] ev [7];
    ev = '{e0, e1, e2, e3, e4, e5, e6};
    i2c_start;
    wr_byte(8'hD4, a0); wr_byte(idx, a1);
    i2c_start;
    wr_byte(8'hD5, a2);
    chk({req, " read acks"}, int'({a0, a1, a2}), 3'b111);
    exp_q.push_back(ecnt); tag_q.push_back({req, " count"});
    rd_byte(1'b1, b); act_q.push_back(int'(b)); -> got;
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(int'(ev[i])); tag_q.push_back({req, " data"});
      rd_byte(i != n - 1, b); act_q.push_back(int'(b)); -> got;
    end
    i2c_stop;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic a;
    wq(5);
    // R5 reset state
    chk("R5 reset div_a", int'(div_a), 8'h0F);
    chk("R5 reset div_b", int'(div_b), 8'h2E);
    chk("R5 reset enables", int'({out3_en, out4_en}), 2'b11);
    chk("R3 reset sda_oe", int'(sda_oe), 0);
    rst_n = 1'b1;
    wq(10);
    // R3 R4 R6 full read from index 0
    read_txn("R6", 8'd0, 7, 7, 8'h30, 8'h0F, 8'h2E, 8'h00, 8'h00, 8'h00, 8'h01);
    // R2 block write across two registers
    write_txn("R2", 8'd1, 8'd2, 8'hA5, 8'h3C, 2);
    chk("R2 div_a", int'(div_a), 8'hA5);
    chk("R2 div_b", int'(div_b), 8'h3C);
    // R5 enable bits, reserved bits read 0
    write_txn("R5", 8'd0, 8'd1, 8'h00, 8'h00, 1);
    chk("R5 enables off", int'({out3_en, out4_en}), 2'b00);
    write_txn("R5", 8'd0, 8'd1, 8'hFF, 8'h00, 1);
    chk("R5 enables on", int'({out3_en, out4_en}), 2'b11);
    read_txn("R5", 8'd0, 1, 7, 8'h30, 0, 0, 0, 0, 0, 0);
    // R7 write to id register ignored
    write_txn("R7", 8'd6, 8'd1, 8'h55, 8'h00, 1);
    read_txn("R7", 8'd6, 1, 1, 8'h01, 0, 0, 0, 0, 0, 0);
    // R8 extra byte beyond count
    write_txn("R8", 8'd1, 8'd1, 8'h11, 8'h22, 2);
    chk("R8 div_a", int'(div_a), 8'h11);
    chk("R8 div_b kept", int'(div_b), 8'h3C);
    // R1 foreign address
    i2c_start;
    wr_byte(8'hD6, a);
    chk("R1 foreign addr ack", int'(a), 0);
    wr_byte(8'h01, a); wr_byte(8'h01, a); wr_byte(8'h77, a);
    i2c_stop;
    chk("R1 foreign addr div_a", int'(div_a), 8'h11);
    // R9 R4 read past the end
    read_txn("R9", 8'd5, 3, 2, 8'h00, 8'h01, 8'h00, 0, 0, 0, 0);
    read_txn("R4", 8'd9, 1, 0, 8'h00, 0, 0, 0, 0, 0, 0);
    // R10 stop in middle of a data byte
    begin
      logic r;
      i2c_start;
      wr_byte(8'hD4, a); wr_byte(8'h02, a); wr_byte(8'h01, a);
      for (int i = 0; i < 4; i++) bit_io(1'b0, r);
      sda_m = 1'b0; wq(Q);
      scl_m = 1'b1; wq(Q); sda_m = 1'b1; wq(2 * Q);
    end
    chk("R10 partial byte dropped", int'(div_b), 8'h3C);
    chk("R10 sda released", int'(sda_oe), 0);
    write_txn("R10", 8'd1, 8'd1, 8'h66, 8'h00, 1);
    chk("R10 recovery write", int'(div_a), 8'h66);
    // R11 glitches on SCL inside each high phase
    glitch = 1'b1;
    write_txn("R11", 8'd2, 8'd1, 8'h5A, 8'h00, 1);
    glitch = 1'b0;
    chk("R11 glitch write", int'(div_b), 8'h5A);
    wq(20);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule